// File: doc/BRIEF.md
# Per-Bank In-Order DRAM Command Scheduler

This block sits between the request side of a memory controller and the DRAM command bus. Each incoming read or write request names a bank, a row and a column. The block places it in a small first-in first-out queue owned by that bank. Each bank serves its own queue strictly in arrival order. Only the request at the head of a queue is compared with that bank's open row, so no associative search over queued entries is needed. Banks advance independently of one another, which gives bank-level parallelism at the cost of some row locality.

For each head request the bank logic picks one of three actions. A row hit goes straight to a read or write. A closed bank needs an activate first. A bank with a different row open needs a precharge, then an activate, then the column access. Per-bank down-counters enforce the activate-to-column delay, the precharge-to-activate delay and the activate-to-activate row cycle time. A round-robin arbiter picks one ready bank per cycle, so at most one command leaves the block each cycle. One cycle after every column command, a completion pulse marks the end of that request.

The number of banks must be a power of two and at least 2.

Top module: `dram_bank_scheduler`

## Requirements
- R1: Requests to the same bank produce their commands in acceptance order, and every accepted request eventually produces its column command, so none is lost.
- R2: If the head row differs from the bank's open row, the bank issues a precharge first. The precharge carries the open row. It is followed by an activate of the head row and then the column command. Command codes on `cmd_op` are: 0 = precharge, 1 = activate, 2 = read, 3 = write.
- R3: If the head row equals the bank's open row, the bank issues only the read (code 2) or the write (code 3), with no activate.
- R4: After reset every bank is closed, so the first command for a bank is an activate. While reset is held, `cmd_valid` and `done_o` are 0 and `req_ready` is 1.
- R5: A column command to a bank comes at least `T_RCD` cycles after that bank's activate.
- R6: An activate comes at least `T_RP` cycles after the same bank's precharge.
- R7: Two activates to the same bank are at least `T_RC` cycles apart.
- R8: `req_ready` is 0 exactly when the queue of the bank on `req_bank` already holds `QDEPTH` entries (default 8).
- R9: At most one command is issued per cycle. When several banks are ready, the grant rotates round-robin, starting from the bank after the last one granted.
- R10: `done_o` is 1 for one cycle, in the cycle right after each read or write command, and at no other time.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| req_valid | input | 1 | Request present |
| req_ready | output | 1 | Target bank queue can accept |
| req_bank | input | BANK_W | Target bank |
| req_row | input | ROW_W | Target row |
| req_col | input | COL_W | Target column |
| req_write | input | 1 | 1 = write, 0 = read |
| cmd_valid | output | 1 | Command issued this cycle |
| cmd_op | output | 2 | 0 precharge, 1 activate, 2 read, 3 write |
| cmd_bank | output | BANK_W | Bank addressed |
| cmd_row | output | ROW_W | Row (open row for precharge) |
| cmd_col | output | COL_W | Column of the head request |
| done_o | output | 1 | Pulse one cycle after a column command |

## Verification
On every cycle the bound checker rebuilds each bank's open or closed state and queue occupancy from the ports alone. From that it checks that commands only target banks in a legal state, that the three timing gaps hold, that ready matches occupancy, and that the completion pulse follows the column commands. Only the bench scenarios can show the rest. These are the exact command sequence per bank against a model of hits and misses, the arrival-order service, the absence of lost requests after a queue fills, and the alternating grant order when two banks compete.

// File: rtl/bsched_pkg.sv
package bsched_pkg;
  typedef enum logic [1:0] {
    OP_PRE = 2'd0,
    OP_ACT = 2'd1,
    OP_RD  = 2'd2,
    OP_WR  = 2'd3
  } dram_op_e;

  function automatic logic is_col(input dram_op_e op);
    return (op == OP_RD) || (op == OP_WR);
  endfunction
endpackage

// File: rtl/bsched_fifo.sv
module bsched_fifo #(
  parameter int W     = 8,
  parameter int DEPTH = 8
) (
  input  logic         clk,
  input  logic         rst_n,
  input  logic         push,
  input  logic [W-1:0] din,
  input  logic         pop,
  output logic [W-1:0] head,
  output logic         empty,
  output logic         full
);
  localparam int AW = (DEPTH > 1) ? $clog2(DEPTH) : 1;
  localparam int CW = $clog2(DEPTH + 1);

  logic [W-1:0]  mem [DEPTH];
  logic [AW-1:0] wp_q, wp_n, rp_q, rp_n;
  logic [CW-1:0] cnt_q, cnt_n;

  assign empty = (cnt_q == '0);
  assign full  = (cnt_q == CW'(DEPTH));
  assign head  = mem[rp_q];

  always_comb begin
    wp_n  = wp_q;
    rp_n  = rp_q;
    cnt_n = cnt_q;
    if (push) wp_n = (wp_q == AW'(DEPTH - 1)) ? '0 : wp_q + 1'b1;
    if (pop)  rp_n = (rp_q == AW'(DEPTH - 1)) ? '0 : rp_q + 1'b1;
    if (push && !pop) cnt_n = cnt_q + 1'b1;
    else if (pop && !push) cnt_n = cnt_q - 1'b1;
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      wp_q  <= '0;
      rp_q  <= '0;
      cnt_q <= '0;
    end else begin
      wp_q  <= wp_n;
      rp_q  <= rp_n;
      cnt_q <= cnt_n;
    end
  end

  always_ff @(posedge clk) begin
    if (push) mem[wp_q] <= din;
  end
endmodule

// File: rtl/bsched_bank.sv
module bsched_bank
  import bsched_pkg::*;
#(
  parameter int ROW_W = 8,
  parameter int T_RCD = 3,
  parameter int T_RP  = 3,
  parameter int T_RC  = 8
) (
  input  logic             clk,
  input  logic             rst_n,
  input  logic             head_vld,
  input  logic [ROW_W-1:0] head_row,
  input  logic             head_wr,
  input  logic             grant,
  output logic             want,
  output dram_op_e         op,
  output logic [ROW_W-1:0] cmd_row,
  output logic             pop
);
  localparam int TMAX = (T_RC > T_RCD) ? ((T_RC > T_RP) ? T_RC : T_RP)
                                       : ((T_RCD > T_RP) ? T_RCD : T_RP);
  localparam int TW = $clog2(TMAX + 1);

  logic             open_q, open_n;
  logic [ROW_W-1:0] row_q, row_n;
  logic [TW-1:0]    busy_q, busy_n;
  logic [TW-1:0]    rc_q, rc_n;
  logic             hit;

  assign hit = open_q && (row_q == head_row);

  always_comb begin
    if (!open_q)  op = OP_ACT;
    else if (hit) op = head_wr ? OP_WR : OP_RD;
    else          op = OP_PRE;
  end

  assign want    = head_vld && (busy_q == '0) && ((op != OP_ACT) || (rc_q == '0));
  assign cmd_row = (op == OP_PRE) ? row_q : head_row;
  assign pop     = grant && is_col(op);

  always_comb begin
    open_n = open_q;
    row_n  = row_q;
    busy_n = (busy_q != '0) ? busy_q - 1'b1 : busy_q;
    rc_n   = (rc_q != '0) ? rc_q - 1'b1 : rc_q;
    if (grant) begin
      unique case (op)
        OP_ACT: begin
          open_n = 1'b1;
          row_n  = head_row;
          busy_n = TW'(T_RCD - 1);
          rc_n   = TW'(T_RC - 1);
        end
        OP_PRE: begin
          open_n = 1'b0;
          busy_n = TW'(T_RP - 1);
        end
        default: ;
      endcase
    end
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      open_q <= 1'b0;
      row_q  <= '0;
      busy_q <= '0;
      rc_q   <= '0;
    end else begin
      open_q <= open_n;
      row_q  <= row_n;
      busy_q <= busy_n;
      rc_q   <= rc_n;
    end
  end
endmodule

// File: rtl/bsched_rr_arb.sv
module bsched_rr_arb #(
  parameter int N = 4
) (
  input  logic                 clk,
  input  logic                 rst_n,
  input  logic [N-1:0]         req,
  output logic [N-1:0]         gnt,
  output logic [$clog2(N)-1:0] gnt_idx,
  output logic                 gnt_vld
);
  localparam int IW = $clog2(N);

  logic [IW-1:0] ptr_q, ptr_n;

  always_comb begin
    gnt     = '0;
    gnt_idx = ptr_q;
    gnt_vld = 1'b0;
    for (int i = 0; i < N; i++) begin
      int j;
      j = (int'(ptr_q) + i) % N;
      if (!gnt_vld && req[j]) begin
        gnt[j]  = 1'b1;
        gnt_idx = IW'(j);
        gnt_vld = 1'b1;
      end
    end
  end

  always_comb begin
    ptr_n = ptr_q;
    if (gnt_vld) ptr_n = gnt_idx + 1'b1;
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) ptr_q <= '0;
    else        ptr_q <= ptr_n;
  end
endmodule

// File: rtl/dram_bank_scheduler.sv
module dram_bank_scheduler
  import bsched_pkg::*;
#(
  parameter int NUM_BANKS = 4,
  parameter int QDEPTH    = 8,
  parameter int ROW_W     = 8,
  parameter int COL_W     = 6,
  parameter int T_RCD     = 3,
  parameter int T_RP      = 3,
  parameter int T_RC      = 8,
  localparam int BANK_W   = $clog2(NUM_BANKS)
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              req_valid,
  output logic              req_ready,
  input  logic [BANK_W-1:0] req_bank,
  input  logic [ROW_W-1:0]  req_row,
  input  logic [COL_W-1:0]  req_col,
  input  logic              req_write,
  output logic              cmd_valid,
  output logic [1:0]        cmd_op,
  output logic [BANK_W-1:0] cmd_bank,
  output logic [ROW_W-1:0]  cmd_row,
  output logic [COL_W-1:0]  cmd_col,
  output logic              done_o
);
  localparam int EW = ROW_W + COL_W + 1;

  logic [NUM_BANKS-1:0] full, empty, want, gnt;
  logic [EW-1:0]        head  [NUM_BANKS];
  dram_op_e             b_op  [NUM_BANKS];
  logic [ROW_W-1:0]     b_row [NUM_BANKS];
  logic [BANK_W-1:0]    gidx;
  logic                 gvld;
  logic                 done_q, done_n;

  assign req_ready = !full[req_bank];

  for (genvar b = 0; b < NUM_BANKS; b++) begin : g_bank
    logic push, pop;
    assign push = req_valid && req_ready && (req_bank == BANK_W'(b));

    bsched_fifo #(.W(EW), .DEPTH(QDEPTH)) u_q (
      .clk(clk), .rst_n(rst_n), .push(push),
      .din({req_row, req_col, req_write}), .pop(pop),
      .head(head[b]), .empty(empty[b]), .full(full[b])
    );

    bsched_bank #(.ROW_W(ROW_W), .T_RCD(T_RCD), .T_RP(T_RP), .T_RC(T_RC)) u_bank (
      .clk(clk), .rst_n(rst_n), .head_vld(!empty[b]),
      .head_row(head[b][EW-1 -: ROW_W]), .head_wr(head[b][0]),
      .grant(gnt[b]), .want(want[b]), .op(b_op[b]),
      .cmd_row(b_row[b]), .pop(pop)
    );
  end

  bsched_rr_arb #(.N(NUM_BANKS)) u_arb (
    .clk(clk), .rst_n(rst_n), .req(want),
    .gnt(gnt), .gnt_idx(gidx), .gnt_vld(gvld)
  );

  assign cmd_valid = gvld;
  assign cmd_op    = b_op[gidx];
  assign cmd_bank  = gidx;
  assign cmd_row   = b_row[gidx];
  assign cmd_col   = head[gidx][COL_W:1];

  assign done_n = gvld && is_col(b_op[gidx]);

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) done_q <= 1'b0;
    else        done_q <= done_n;
  end

  assign done_o = done_q;
endmodule

// File: rtl/bsched_checker.sv
module bsched_checker #(
  parameter int NUM_BANKS = 4,
  parameter int QDEPTH    = 8,
  parameter int ROW_W     = 8,
  parameter int COL_W     = 6,
  parameter int T_RCD     = 3,
  parameter int T_RP      = 3,
  parameter int T_RC      = 8,
  localparam int BANK_W   = $clog2(NUM_BANKS)
) (
  input logic              clk,
  input logic              rst_n,
  input logic              req_valid,
  input logic              req_ready,
  input logic [BANK_W-1:0] req_bank,
  input logic [ROW_W-1:0]  req_row,
  input logic [COL_W-1:0]  req_col,
  input logic              req_write,
  input logic              cmd_valid,
  input logic [1:0]        cmd_op,
  input logic [BANK_W-1:0] cmd_bank,
  input logic [ROW_W-1:0]  cmd_row,
  input logic [COL_W-1:0]  cmd_col,
  input logic              done_o
);
  localparam int SW = 8;
  localparam int OW = $clog2(QDEPTH + 1);

  logic [NUM_BANKS-1:0] open_c;
  logic [SW-1:0]        since_act [NUM_BANKS];
  logic [SW-1:0]        since_pre [NUM_BANKS];
  logic [OW-1:0]        occ [NUM_BANKS];
  logic                 prev_col;
  logic                 is_act, is_pre, is_colc;

  assign is_act  = cmd_valid && (cmd_op == 2'd1);
  assign is_pre  = cmd_valid && (cmd_op == 2'd0);
  assign is_colc = cmd_valid && cmd_op[1];

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      open_c   <= '0;
      prev_col <= 1'b0;
      for (int b = 0; b < NUM_BANKS; b++) begin
        since_act[b] <= '1;
        since_pre[b] <= '1;
        occ[b]       <= '0;
      end
    end else begin
      prev_col <= is_colc;
      for (int b = 0; b < NUM_BANKS; b++) begin
        logic psh, pp;
        psh = req_valid && req_ready && (req_bank == BANK_W'(b));
        pp  = is_colc && (cmd_bank == BANK_W'(b));
        if (psh && !pp) occ[b] <= occ[b] + 1'b1;
        else if (pp && !psh) occ[b] <= occ[b] - 1'b1;
        if (is_act && cmd_bank == BANK_W'(b)) begin
          since_act[b] <= SW'(1);
          open_c[b]    <= 1'b1;
        end else if (since_act[b] != '1) begin
          since_act[b] <= since_act[b] + 1'b1;
        end
        if (is_pre && cmd_bank == BANK_W'(b)) begin
          since_pre[b] <= SW'(1);
          open_c[b]    <= 1'b0;
        end else if (since_pre[b] != '1) begin
          since_pre[b] <= since_pre[b] + 1'b1;
        end
      end
    end
  end

  a_r2_col_needs_open: assert property (@(posedge clk) disable iff (!rst_n)
    is_colc |-> open_c[cmd_bank]);
  a_r2_pre_needs_open: assert property (@(posedge clk) disable iff (!rst_n)
    is_pre |-> open_c[cmd_bank]);
  a_r4_act_needs_closed: assert property (@(posedge clk) disable iff (!rst_n)
    is_act |-> !open_c[cmd_bank]);
  a_r5_trcd_met: assert property (@(posedge clk) disable iff (!rst_n)
    is_colc |-> (since_act[cmd_bank] >= SW'(T_RCD)));
  a_r6_trp_met: assert property (@(posedge clk) disable iff (!rst_n)
    is_act |-> (since_pre[cmd_bank] >= SW'(T_RP)));
  a_r7_trc_met: assert property (@(posedge clk) disable iff (!rst_n)
    is_act |-> (since_act[cmd_bank] >= SW'(T_RC)));
  a_r8_ready_matches_occ: assert property (@(posedge clk) disable iff (!rst_n)
    req_ready == (occ[req_bank] < OW'(QDEPTH)));
  a_r10_done_follows_col: assert property (@(posedge clk) disable iff (!rst_n)
    done_o == prev_col);
endmodule

bind dram_bank_scheduler bsched_checker #(
  .NUM_BANKS(NUM_BANKS), .QDEPTH(QDEPTH), .ROW_W(ROW_W), .COL_W(COL_W),
  .T_RCD(T_RCD), .T_RP(T_RP), .T_RC(T_RC)
) u_chk (
  .clk(clk), .rst_n(rst_n), .req_valid(req_valid), .req_ready(req_ready),
  .req_bank(req_bank), .req_row(req_row), .req_col(req_col),
  .req_write(req_write), .cmd_valid(cmd_valid), .cmd_op(cmd_op),
  .cmd_bank(cmd_bank), .cmd_row(cmd_row), .cmd_col(cmd_col), .done_o(done_o)
);

// File: tb/tb_dram_bank_scheduler.sv
module tb_dram_bank_scheduler;
  localparam int NB = 4, QD = 8, RW = 8, CW = 6;
  localparam int T_RCD = 3, T_RP = 3, T_RC = 8;
  localparam int BW = 2;
  localparam int IW = 2 + RW + CW;

  logic          clk = 1'b0;
  logic          rst_n;
  logic          req_valid, req_ready, req_write;
  logic [BW-1:0] req_bank;
  logic [RW-1:0] req_row;
  logic [CW-1:0] req_col;
  logic          cmd_valid, done_o;
  logic [1:0]    cmd_op;
  logic [BW-1:0] cmd_bank;
  logic [RW-1:0] cmd_row;
  logic [CW-1:0] cmd_col;

  int checks = 0, errors = 0, cyc = 0;
  logic [IW-1:0] exp_q [NB][$];
  logic          m_open [NB];
  logic [RW-1:0] m_row  [NB];
  int            occ [NB];
  int            last_act [NB];
  int            last_pre [NB];
  logic          prev_col = 1'b0;
  logic          rr_mode = 1'b0;
  int            rr_log [$];
  int            stall_cycles = 0;

  always #10 clk = ~clk;

  dram_bank_scheduler #(.NUM_BANKS(NB), .QDEPTH(QD), .ROW_W(RW), .COL_W(CW),
    .T_RCD(T_RCD), .T_RP(T_RP), .T_RC(T_RC)) dut (
    .clk(clk), .rst_n(rst_n), .req_valid(req_valid), .req_ready(req_ready),
    .req_bank(req_bank), .req_row(req_row), .req_col(req_col),
    .req_write(req_write), .cmd_valid(cmd_valid), .cmd_op(cmd_op),
    .cmd_bank(cmd_bank), .cmd_row(cmd_row), .cmd_col(cmd_col), .done_o(done_o));

  task automatic check(input bit ok, input string req, input int act, input int exp);
    checks++;
    if (!ok) begin
      errors++;
      $display("FAIL %s actual=%0d expected=%0d at cycle %0d", req, act, exp, cyc);
    end
  endtask

  // driver: waits for acceptance, then records expected commands
  task automatic send(input int b, input int row, input int col, input bit wr);
    @(negedge clk);
    req_valid = 1'b1; req_bank = BW'(b); req_row = RW'(row);
    req_col = CW'(col); req_write = wr;
    #1;
    while (!req_ready) begin
      stall_cycles++;
      @(negedge clk); #1;
    end
    if (m_open[b] && m_row[b] == RW'(row)) begin
      exp_q[b].push_back({wr ? 2'd3 : 2'd2, RW'(row), CW'(col)});
    end else begin
      if (m_open[b]) exp_q[b].push_back({2'd0, m_row[b], CW'(col)});
      exp_q[b].push_back({2'd1, RW'(row), CW'(col)});
      exp_q[b].push_back({wr ? 2'd3 : 2'd2, RW'(row), CW'(col)});
    end
    m_open[b] = 1'b1;
    m_row[b]  = RW'(row);
    @(posedge clk); #1;
    req_valid = 1'b0;
  endtask

  function automatic bit all_empty();
    for (int b = 0; b < NB; b++) if (exp_q[b].size() != 0) return 1'b0;
    return 1'b1;
  endfunction

  // monitor: samples 5 ns before each rising edge
  always begin
    @(posedge clk); #15;
    if (rst_n) begin
      cyc++;
      check(done_o == prev_col, "R10 done pulse", int'(done_o), int'(prev_col));
      if (req_valid)
        check(req_ready == (occ[req_bank] < QD), "R8 ready vs occupancy",
              int'(req_ready), int'(occ[req_bank] < QD));
      if (req_valid && req_ready) occ[req_bank]++;
      prev_col = cmd_valid && cmd_op[1];
      if (cmd_valid) begin
        int b;
        b = int'(cmd_bank);
        if (exp_q[b].size() == 0) begin
          check(1'b0, "R1 unexpected command", int'(cmd_op), -1);
        end else begin
          logic [IW-1:0] e;
          e = exp_q[b].pop_front();
          check({cmd_op, cmd_row, cmd_col} == e, "R1 R2 R3 command order/content",
                int'({cmd_op, cmd_row, cmd_col}), int'(e));
        end
        if (cmd_op == 2'd1) begin
          check(cyc - last_pre[b] >= T_RP, "R6 tRP", cyc - last_pre[b], T_RP);
          check(cyc - last_act[b] >= T_RC, "R7 tRC", cyc - last_act[b], T_RC);
          last_act[b] = cyc;
        end else if (cmd_op == 2'd0) begin
          last_pre[b] = cyc;
        end else begin
          check(cyc - last_act[b] >= T_RCD, "R5 tRCD", cyc - last_act[b], T_RCD);
          occ[b]--;
          if (rr_mode) rr_log.push_back(b);
        end
      end
    end
  end

  initial begin
    #(20 * 200000);
    errors++;
    $display("FAIL watchdog expired at cycle %0d", cyc);
    $display("Simulation finished: %0d checks, %0d errors", checks, errors);
    $finish;
  end

  initial begin
    for (int b = 0; b < NB; b++) begin
      m_open[b] = 1'b0; m_row[b] = '0; occ[b] = 0;
      last_act[b] = -1000; last_pre[b] = -1000;
    end
    rst_n = 1'b0; req_valid = 1'b0; req_bank = '0; req_row = '0;
    req_col = '0; req_write = 1'b0;
    repeat (3) @(posedge clk);
    #5;
    // R4: idle outputs during reset
    check(cmd_valid == 1'b0, "R4 cmd_valid in reset", int'(cmd_valid), 0);
    check(done_o == 1'b0, "R4 done_o in reset", int'(done_o), 0);
    check(req_ready == 1'b1, "R4 req_ready in reset", int'(req_ready), 1);
    @(negedge clk); rst_n = 1'b1;

    // R9: two banks compete, grants must alternate; R4 first command is ACT
    rr_mode = 1'b1;
    for (int i = 0; i < 4; i++) begin
      send(2, 20, i, 1'b0);
      send(3, 30, i + 8, 1'b1);
    end
    while (!all_empty()) @(posedge clk);
    repeat (2) @(posedge clk);
    rr_mode = 1'b0;
    check(rr_log.size() == 8, "R9 column count", rr_log.size(), 8);
    for (int i = 0; i < rr_log.size(); i++)
      check(rr_log[i] == ((i % 2 == 0) ? 2 : 3), "R9 round-robin order",
            rr_log[i], (i % 2 == 0) ? 2 : 3);

    // R3 hits then R2 miss on bank 0
    send(0, 5, 1, 1'b0);
    send(0, 5, 2, 1'b1);
    send(0, 5, 3, 1'b0);
    send(0, 9, 4, 1'b1);
    send(0, 9, 5, 1'b0);
    // mixed banks, R1 order per bank
    send(1, 7, 10, 1'b0);
    send(2, 21, 11, 1'b1);
    send(1, 7, 12, 1'b1);
    send(3, 30, 13, 1'b0);
    send(2, 20, 14, 1'b0);
    send(0, 5, 15, 1'b1);

    // R8: flood bank 1 with row misses until its queue fills
    for (int i = 0; i < 14; i++) send(1, 100 + (i % 2), i, i[0]);
    check(stall_cycles > 0, "R8 queue filled and stalled", stall_cycles, 1);

    // R1: everything accepted must drain
    for (int t = 0; t < 2000 && !all_empty(); t++) @(posedge clk);
    repeat (3) @(posedge clk);
    check(all_empty(), "R1 all requests served", int'(all_empty()), 1);
    #15;
    check(cmd_valid == 1'b0, "R1 idle after drain", int'(cmd_valid), 0);

    $display("Simulation finished: %0d checks, %0d errors", checks, errors);
    $finish;
  end
endmodule